// File: doc/BRIEF.md
# Serial Command and Fault-Status Register for a Four-Channel Load Switch

This block is the host-facing register of a four-channel load-switch controller. During each chip-select window the host clocks an 8-bit command in on SDI. While that happens, a byte of fault status for the four channels leaves on SDO, two bits per channel. When chip select is released after a complete frame, the command takes effect. It supplies four channel enables, a 3-bit deglitch-time select for the fault filters and a sleep request. Each channel-on output is the OR of its serial enable and a dedicated parallel input, so real-time control bypasses the serial link.

The serial pins are oversampled by the block's own clock, passed through a synchronizer and turned into edge strobes. While chip select is high, the shift register holds live fault status. When chip select goes low, that status is frozen and shifted out most significant bit first. Bits that arrive on SDI follow the status out of SDO after eight clocks, so several devices can share one chip select and be clocked as a single long chain. A fault interrupt flag is set by any non-normal fault code and held. It is cleared only while chip select is low.

Top module: `lsw_spi_ctrl`

## Requirements
- R1: After reset, every channel enable, the deglitch select and the sleep bit are 0. The fault interrupt is 0, SDO is not driven, and each channel-on output equals its parallel input.
- R2: The SDO drive enable is 0 whenever CS_n is high and 1 while CS_n is low, after the synchronizer delay.
- R3: While CS_n is high, the shift register loads the fault code input. When CS_n falls, the first bit on SDO is bit 7 and the rest follow most significant bit first. Channel 4 owns bits 7:6 and channel 1 owns bits 1:0. Each code is 00 normal, 01 open-load, 10 over-current, 11 short-to-ground.
- R4: SDI is sampled on a rising SCLK edge. SDO changes only after a falling SCLK edge, never after a rising one.
- R5: A rising CS_n after exactly 8 falling SCLK edges applies the received byte, taken most significant bit first. Bits 7:4 are the enables of channels 4..1, bits 3:1 are the deglitch select and bit 0 is sleep. No other event changes these outputs.
- R6: A frame with other than 8 falling SCLK edges (7, 9 or 16) leaves the enables, deglitch select and sleep unchanged.
- R7: Each channel-on output is 1 when its serial enable or its parallel input is 1.
- R8: In a frame longer than 8 bits, SDO carries the SDI bits delayed by 8 clocks after the fault byte.
- R9: The fault interrupt sets while CS_n is high and any fault code is non-zero. It stays set after the fault clears and is cleared while CS_n is low.
- R10: An asserted rst_ni clears the command outputs at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversamples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out (0 when not driven) |
| sdo_oe_o | output | 1 | Drive enable for the SDO pad |
| par_on_i | input | 4 | Parallel channel-on inputs |
| fault_code_i | input | 8 | Fault codes, 2 bits per channel, channel 4 highest |
| chan_on_o | output | 4 | Channel-on: serial enable OR parallel input |
| dgl_sel_o | output | 3 | Deglitch-time select |
| sleep_o | output | 1 | Sleep request |
| fault_irq_o | output | 1 | Latched fault interrupt, active high |

## Verification
Every pin change reaches the logic after the synchronizer stages. The resulting action then lands on the next clock edge, so SDO, the drive enable and the interrupt settle three clock edges after a pin moves, with the default of two synchronizer stages. The command outputs settle in the same way after CS_n rises. The parallel-input path to chan_on_o is combinational and is due at once. The bench changes pins just after a falling clock edge and holds each level for four or more clocks before it samples, so each sample is taken after the result is due. It also samples SDO just after a rising SCLK edge has been processed, to show that the bit has not moved yet.

// File: rtl/lsw_spi_pkg.sv
package lsw_spi_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_OPEN    = 2'b01,
    FLT_OVERCUR = 2'b10,
    FLT_SHORT   = 2'b11
  } fault_code_e;

  localparam int unsigned CODE_W = 2;
endpackage

// File: rtl/lsw_pin_sync.sv
module lsw_pin_sync #(
  parameter int unsigned     W       = 3,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      stg_q[0] <= pin_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stg_q[STAGES-1] & prev_q;
endmodule

// File: rtl/lsw_shift_core.sv
module lsw_shift_core #(
  parameter int unsigned FRAME_W = 8,
  parameter int unsigned CNT_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               desel_i,
  input  logic               sclk_rise_i,
  input  logic               sclk_fall_i,
  input  logic               sdi_i,
  input  logic [FRAME_W-1:0] load_i,
  output logic [FRAME_W-1:0] shreg_o,
  output logic               frame_ok_o,
  output logic               sdo_o
);
  logic [FRAME_W-1:0] shreg_q;
  logic               samp_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      samp_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (desel_i) begin
      // deselected: register mirrors live fault status
      shreg_q <= load_i;
      cnt_q   <= '0;
    end else begin
      if (sclk_rise_i) samp_q <= sdi_i;
      if (sclk_fall_i) begin
        shreg_q <= {shreg_q[FRAME_W-2:0], samp_q};
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign shreg_o    = shreg_q;
  assign frame_ok_o = (cnt_q == CNT_W'(FRAME_W));
  assign sdo_o      = shreg_q[FRAME_W-1];
endmodule

// File: rtl/lsw_cmd_regs.sv
module lsw_cmd_regs #(
  parameter int unsigned N_CH = 4,
  parameter int unsigned DG_W = 3,
  localparam int unsigned FRAME_W = N_CH + DG_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               apply_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [N_CH-1:0]    par_i,
  output logic [N_CH-1:0]    chan_on_o,
  output logic [DG_W-1:0]    dgl_o,
  output logic               sleep_o
);
  logic [N_CH-1:0] en_q;
  logic [DG_W-1:0] dg_q;
  logic            slp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      dg_q  <= '0;
      slp_q <= 1'b0;
    end else if (apply_i) begin
      en_q  <= frame_i[FRAME_W-1 -: N_CH];
      dg_q  <= frame_i[DG_W:1];
      slp_q <= frame_i[0];
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_or
    assign chan_on_o[g] = en_q[g] | par_i[g];
  end

  assign dgl_o   = dg_q;
  assign sleep_o = slp_q;
endmodule

// File: rtl/lsw_fault_irq.sv
module lsw_fault_irq
  import lsw_spi_pkg::*;
#(
  parameter int unsigned N_CH = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   desel_i,
  input  logic [N_CH*CODE_W-1:0] code_i,
  output logic                   irq_o
);
  logic [N_CH-1:0] hit;
  logic            irq_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_hit
    assign hit[g] = (code_i[g*CODE_W +: CODE_W] != FLT_NONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_q <= 1'b0;
    else if (!desel_i) irq_q <= 1'b0;
    else               irq_q <= irq_q | (|hit);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/lsw_spi_ctrl.sv
module lsw_spi_ctrl
  import lsw_spi_pkg::*;
#(
  parameter int unsigned N_CH        = 4,
  parameter int unsigned DG_W        = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned FRAME_W    = N_CH + DG_W + 1,
  localparam int unsigned FLT_W      = N_CH * CODE_W,
  localparam int unsigned CNT_W      = $clog2(FRAME_W) + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic             sdi_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  input  logic [N_CH-1:0]  par_on_i,
  input  logic [FLT_W-1:0] fault_code_i,
  output logic [N_CH-1:0]  chan_on_o,
  output logic [DG_W-1:0]  dgl_sel_o,
  output logic             sleep_o,
  output logic             fault_irq_o
);
  logic [2:0]         pin_lvl, pin_rise, pin_fall;
  logic               cs_s, cs_rise, sclk_rise, sclk_fall, sdi_s;
  logic [FRAME_W-1:0] shreg;
  logic               frame_ok, sdo_raw;
  logic               unused_edges;

  lsw_pin_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({cs_ni, sclk_i, sdi_i}),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign cs_s      = pin_lvl[2];
  assign cs_rise   = pin_rise[2];
  assign sclk_rise = pin_rise[1];
  assign sclk_fall = pin_fall[1];
  assign sdi_s     = pin_lvl[0];
  assign unused_edges = ^{pin_lvl[1], pin_fall[2], pin_rise[0], pin_fall[0]};

  lsw_shift_core #(
    .FRAME_W(FRAME_W), .CNT_W(CNT_W)
  ) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .desel_i     (cs_s),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .sdi_i       (sdi_s),
    .load_i      (fault_code_i),
    .shreg_o     (shreg),
    .frame_ok_o  (frame_ok),
    .sdo_o       (sdo_raw)
  );

  lsw_cmd_regs #(
    .N_CH(N_CH), .DG_W(DG_W)
  ) u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .apply_i   (cs_rise & frame_ok),
    .frame_i   (shreg),
    .par_i     (par_on_i),
    .chan_on_o (chan_on_o),
    .dgl_o     (dgl_sel_o),
    .sleep_o   (sleep_o)
  );

  lsw_fault_irq #(
    .N_CH(N_CH)
  ) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .desel_i (cs_s),
    .code_i  (fault_code_i),
    .irq_o   (fault_irq_o)
  );

  assign sdo_oe_o = ~cs_s;
  assign sdo_o    = sdo_raw & ~cs_s;
endmodule

// File: rtl/lsw_spi_ctrl_chk.sv
module lsw_spi_ctrl_chk #(
  parameter int unsigned N_CH = 4,
  parameter int unsigned DG_W = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cs_s_i,
  input logic            cs_rise_i,
  input logic            sclk_fall_i,
  input logic            frame_ok_i,
  input logic            sdo_o,
  input logic            sdo_oe_o,
  input logic [N_CH-1:0] par_on_i,
  input logic [N_CH-1:0] chan_on_o,
  input logic [DG_W-1:0] dgl_sel_o,
  input logic            sleep_o,
  input logic            fault_irq_o
);
  // R5
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_rise_i |=> $stable({chan_on_o & ~par_on_i, dgl_sel_o, sleep_o}) || !$stable(par_on_i));

  // R6
  bad_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && !frame_ok_i) |=> $stable({dgl_sel_o, sleep_o}));

  // R4
  sdo_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && $past(sdo_oe_o) && !$stable(sdo_o)) |-> $past(sclk_fall_i));

  // R9
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s_i |=> !fault_irq_o);

  // R7
  par_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_on_i & ~chan_on_o) == '0);
endmodule

bind lsw_spi_ctrl lsw_spi_ctrl_chk #(.N_CH(N_CH), .DG_W(DG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_s_i      (cs_s),
  .cs_rise_i   (cs_rise),
  .sclk_fall_i (sclk_fall),
  .frame_ok_i  (frame_ok),
  .sdo_o       (sdo_o),
  .sdo_oe_o    (sdo_oe_o),
  .par_on_i    (par_on_i),
  .chan_on_o   (chan_on_o),
  .dgl_sel_o   (dgl_sel_o),
  .sleep_o     (sleep_o),
  .fault_irq_o (fault_irq_o)
);

// File: tb/lsw_spi_ctrl_bench.sv
module lsw_spi_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  // {cmd, fault, par, exp_on, exp_dg, exp_sleep}
  localparam logic [27:0] VEC [NV] = '{
    {8'hA5, 8'h00, 4'b0000, 4'b1010, 3'b010, 1'b1},
    {8'h5A, 8'h1B, 4'b0000, 4'b0101, 3'b101, 1'b0},
    {8'h0E, 8'hC0, 4'b1001, 4'b1001, 3'b111, 1'b0},
    {8'hF1, 8'h40, 4'b0110, 4'b1111, 3'b000, 1'b1},
    {8'h36, 8'h24, 4'b0100, 4'b0111, 3'b011, 1'b0}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1;
  logic       sclk_i = 1'b0;
  logic       sdi_i = 1'b0;
  logic       sdo_o, sdo_oe_o;
  logic [3:0] par_on_i = '0;
  logic [7:0] fault_code_i = '0;
  logic [3:0] chan_on_o;
  logic [2:0] dgl_sel_o;
  logic       sleep_o, fault_irq_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lsw_spi_ctrl u_lsw_spi_ctrl (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .sdi_i, .sdo_o, .sdo_oe_o,
    .par_on_i, .fault_code_i, .chan_on_o, .dgl_sel_o, .sleep_o, .fault_irq_o
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
    rx = '0;
    cs_ni = 1'b0;
    wait_n(6);
    for (int i = 0; i < nbits; i++) begin
      sdi_i = tx[nbits-1-i];
      wait_n(4);
      rx = {rx[14:0], sdo_o};
      sclk_i = 1'b1;
      wait_n(4);
      sclk_i = 1'b0;
      wait_n(4);
    end
    cs_ni = 1'b1;
    wait_n(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rx;
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(6);
    // R1 reset state
    check("R1 chan_on", 16'(chan_on_o), 16'h0);
    check("R1 dgl", 16'(dgl_sel_o), 16'h0);
    check("R1 sleep/irq/oe", 16'({sleep_o, fault_irq_o, sdo_oe_o}), 16'h0);
    par_on_i = 4'b0110;
    #1 check("R1 R7 par passthrough", 16'(chan_on_o), 16'h6);
    par_on_i = '0;

    // R2 drive enable follows CS_n
    cs_ni = 1'b0; wait_n(4);
    check("R2 oe low cs", 16'(sdo_oe_o), 16'h1);
    cs_ni = 1'b1; wait_n(4);
    check("R2 oe high cs", 16'(sdo_oe_o), 16'h0);

    // table: R3 R5 R7 R9
    for (int v = 0; v < NV; v++) begin
      fault_code_i = VEC[v][19:12];
      par_on_i     = VEC[v][11:8];
      wait_n(4);
      xfer({8'h00, VEC[v][27:20]}, 8, rx);
      check("R3 fault byte", rx, 16'(VEC[v][19:12]));
      check("R5 R7 chan_on", 16'(chan_on_o), 16'(VEC[v][7:4]));
      check("R5 dgl", 16'(dgl_sel_o), 16'(VEC[v][3:1]));
      check("R5 sleep", 16'(sleep_o), 16'(VEC[v][0]));
      check("R9 irq set", 16'(fault_irq_o), 16'(VEC[v][19:12] != 8'h00));
    end

    // R6 short and long frames: last command was 36 (en 0011, dg 011)
    par_on_i = '0;
    xfer(16'h007F, 7, rx);
    check("R6 7-bit frame on", 16'(chan_on_o), 16'h3);
    check("R6 7-bit frame dg", 16'({dgl_sel_o, sleep_o}), 16'h6);
    xfer(16'h01FF, 9, rx);
    check("R6 9-bit frame", 16'({chan_on_o, dgl_sel_o, sleep_o}), 16'h36);

    // R8 cascade: 16 clocks
    fault_code_i = 8'h99;
    wait_n(4);
    xfer(16'h3C81, 16, rx);
    check("R8 cascade passthrough", rx, 16'h993C);
    check("R6 16-bit frame", 16'({chan_on_o, dgl_sel_o, sleep_o}), 16'h36);

    // R4 SDO moves only after falling SCLK
    fault_code_i = 8'h80;
    wait_n(4);
    cs_ni = 1'b0; sdi_i = 1'b0;
    wait_n(6);
    check("R4 first bit", 16'(sdo_o), 16'h1);
    sclk_i = 1'b1; wait_n(4);
    check("R4 no change on rise", 16'(sdo_o), 16'h1);
    sclk_i = 1'b0; wait_n(4);
    check("R4 change on fall", 16'(sdo_o), 16'h0);
    cs_ni = 1'b1; wait_n(6);

    // R9 latch holds, cleared by CS_n low
    fault_code_i = 8'h0C; wait_n(5);
    check("R9 set", 16'(fault_irq_o), 16'h1);
    fault_code_i = 8'h00; wait_n(5);
    check("R9 held", 16'(fault_irq_o), 16'h1);
    cs_ni = 1'b0; wait_n(5);
    check("R9 cleared cs low", 16'(fault_irq_o), 16'h0);
    cs_ni = 1'b1; wait_n(5);
    check("R9 stays clear", 16'(fault_irq_o), 16'h0);

    // R10 asynchronous reset
    xfer(16'h00FB, 8, rx);
    check("R5 load FB", 16'({chan_on_o, dgl_sel_o, sleep_o}), 16'hFB);
    #3 rst_ni = 1'b0;
    #1 check("R10 async clear", 16'({chan_on_o, dgl_sel_o, sleep_o}), 16'h0);
    wait_n(2);
    rst_ni = 1'b1;
    wait_n(4);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule